// File: doc/BRIEF.md
# Two-Thread Core Idle State Resolver

This block works out the idle state of one processor core from what its two hardware threads have asked for. Each thread has a tracker. The tracker takes encoded deep-state request pulses, a halt pulse and a wake pulse, and keeps the thread's present state. A thread that asks for a different deep state while already idle first goes back to the active state for one cycle. It enters the new state on the cycle after that.

A merge stage takes the shallowest of the thread states. When the result is C1, it promotes the result to the enhanced C1 variant, but only when that variant is enabled and an input reports that every other core in the package is at C1 or deeper. A sequencing register holds the core state. It forces any change between two idle states to pass through C0, and it gives one-cycle entry and exit strobes. Power-saving logic downstream acts only on the core state, never on a thread request.

Top module: `idle_resolver`

## Requirements
- R1: A synchronous active-high `rst` sets both thread states and `core_state` to C0 and holds both strobes low.
- R2: States are coded on 3 bits as C0=0, C1=1, C1E=2, C3=3, C6=4, C7=5. Thread i appears on `thread_state[3i+2:3i]`. If any thread is in C0, the core is C0. If both threads hold the same state, the core takes that state.
- R3: The core state is the shallowest thread state, which is the numerically lowest code. For example, C3 with C7 gives C3, C6 with C7 gives C6, and C1 with any deeper state gives C1.
- R4: A core resolving to C1 reports C1E (2) only when `c1e_en` and `pkg_idle_ok` are both high. Otherwise it reports C1.
- R5: A `halt_req` pulse places its thread in C1. It takes priority over an encoded request on the same thread in the same cycle.
- R6: A request for a different non-C0 state while a thread is in a non-C0 state moves the thread to C0 on the next cycle, then to the requested state one cycle later. A request for the state the thread already holds changes nothing.
- R7: `core_state` follows the thread states one cycle later. `enter_strb` pulses for one cycle when `core_state` changes to a non-C0 value. `exit_strb` pulses for one cycle when it changes to C0. The two strobes are never high together.
- R8: `core_state` never moves directly between two different non-C0 codes. Such a change shows C0 for exactly one cycle first.
- R9: A `req_valid` pulse whose code is not 1, 3, 4 or 5 is ignored.
- R10: `wake` returns its thread to C0 on the next cycle. It overrides a request in the same cycle and cancels a pending two-step entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-thread encoded request pulse |
| req_code | input | 6 | Per-thread requested state, 3 bits per thread |
| halt_req | input | 2 | Per-thread halt pulse (C1 request) |
| wake | input | 2 | Per-thread wake pulse (return to C0) |
| c1e_en | input | 1 | Enables the enhanced C1 promotion |
| pkg_idle_ok | input | 1 | All other cores are at C1 or deeper |
| thread_state | output | 6 | Current state of each thread, 3 bits per thread |
| core_state | output | 3 | Resolved core state |
| enter_strb | output | 1 | One-cycle pulse on a change into a non-C0 state |
| exit_strb | output | 1 | One-cycle pulse on a change back to C0 |

## Verification
The bench drives mixed deep requests such as C3 with C7, C6 with C7 and C1 with C7. A design that took the deeper state, or the state of a fixed thread, would report the wrong core state. It toggles `pkg_idle_ok` while both threads sit in C1, which makes the core swap between C1 and C1E. A design without the C0 gate would jump straight between the two idle codes, and a design with a badly timed promotion would show C1E with the feature off. It also re-targets a thread that is already idle, repeats a request for the held state, and wakes a thread while an entry is pending. A tracker that skipped the C0 bounce, bounced when it should not, or kept the pending state after a wake would all show up on `thread_state`. Illegal codes and halts that arrive together with encoded requests check the decode priority.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int STW = 3;
  typedef logic [STW-1:0] cstate_t;

  localparam cstate_t ST_ACT = 3'd0;
  localparam cstate_t ST_L1  = 3'd1;
  localparam cstate_t ST_L1E = 3'd2;
  localparam cstate_t ST_L3  = 3'd3;
  localparam cstate_t ST_L6  = 3'd4;
  localparam cstate_t ST_L7  = 3'd5;

  function automatic logic is_req_code(input cstate_t c);
    return (c == ST_L1) || (c == ST_L3) || (c == ST_L6) || (c == ST_L7);
  endfunction
endpackage

// File: rtl/idle_thread_trk.sv
module idle_thread_trk
  import idle_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  cstate_t req_code,
  input  logic    halt_req,
  input  logic    wake,
  output cstate_t state
);
  cstate_t state_q;
  cstate_t pend_q;
  logic    pend_vld_q;
  cstate_t tgt;
  logic    tgt_ok;

  always_comb begin
    tgt    = halt_req ? ST_L1 : req_code;
    tgt_ok = halt_req | (req_valid & is_req_code(req_code));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_ACT;
      pend_q     <= ST_ACT;
      pend_vld_q <= 1'b0;
    end else if (wake) begin
      state_q    <= ST_ACT;
      pend_vld_q <= 1'b0;
    end else if (tgt_ok) begin
      if (state_q == ST_ACT || state_q == tgt) begin
        state_q    <= tgt;
        pend_vld_q <= 1'b0;
      end else begin
        state_q    <= ST_ACT;
        pend_q     <= tgt;
        pend_vld_q <= 1'b1;
      end
    end else if (pend_vld_q) begin
      state_q    <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/idle_core_merge.sv
module idle_core_merge
  import idle_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic [NT*STW-1:0] thr_state,
  input  logic              c1e_en,
  input  logic              pkg_idle_ok,
  output cstate_t           target
);
  cstate_t shallow [NT];

  assign shallow[0] = thr_state[STW-1:0];

  generate
    for (genvar i = 1; i < NT; i++) begin : g_min
      cstate_t cur;
      assign cur        = thr_state[i*STW +: STW];
      assign shallow[i] = (cur < shallow[i-1]) ? cur : shallow[i-1];
    end
  endgenerate

  always_comb begin
    target = shallow[NT-1];
    if (target == ST_L1 && c1e_en && pkg_idle_ok)
      target = ST_L1E;
  end
endmodule

// File: rtl/idle_core_seq.sv
module idle_core_seq
  import idle_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  cstate_t target,
  output cstate_t core_state,
  output logic    enter_strb,
  output logic    exit_strb
);
  cstate_t core_q;
  cstate_t nxt;
  logic    enter_q;
  logic    exit_q;

  always_comb begin
    if (core_q != ST_ACT && target != ST_ACT && target != core_q)
      nxt = ST_ACT;
    else
      nxt = target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q  <= ST_ACT;
      enter_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      core_q  <= nxt;
      enter_q <= (nxt != core_q) && (nxt != ST_ACT);
      exit_q  <= (nxt != core_q) && (nxt == ST_ACT);
    end
  end

  assign core_state = core_q;
  assign enter_strb = enter_q;
  assign exit_strb  = exit_q;
endmodule

// File: rtl/idle_resolver.sv
module idle_resolver
  import idle_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NT-1:0]     req_valid,
  input  logic [NT*STW-1:0] req_code,
  input  logic [NT-1:0]     halt_req,
  input  logic [NT-1:0]     wake,
  input  logic              c1e_en,
  input  logic              pkg_idle_ok,
  output logic [NT*STW-1:0] thread_state,
  output logic [STW-1:0]    core_state,
  output logic              enter_strb,
  output logic              exit_strb
);
  cstate_t target;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      idle_thread_trk u_trk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid[t]),
        .req_code  (req_code[t*STW +: STW]),
        .halt_req  (halt_req[t]),
        .wake      (wake[t]),
        .state     (thread_state[t*STW +: STW])
      );
    end
  endgenerate

  idle_core_merge #(.NT(NT)) u_merge (
    .thr_state   (thread_state),
    .c1e_en      (c1e_en),
    .pkg_idle_ok (pkg_idle_ok),
    .target      (target)
  );

  idle_core_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .target     (target),
    .core_state (core_state),
    .enter_strb (enter_strb),
    .exit_strb  (exit_strb)
  );
endmodule

// File: rtl/idle_resolver_chk.sv
module idle_resolver_chk
  import idle_pkg::*;
#(
  parameter int NT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              c1e_en,
  input logic [NT*STW-1:0] thread_state,
  input logic [STW-1:0]    core_state,
  input logic              enter_strb,
  input logic              exit_strb
);
  logic any_act;
  logic thr_bad;

  always_comb begin
    any_act = 1'b0;
    thr_bad = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (thread_state[i*STW +: STW] == ST_ACT) any_act = 1'b1;
      if (thread_state[i*STW +: STW] == ST_L1E ||
          thread_state[i*STW +: STW] > ST_L7) thr_bad = 1'b1;
    end
  end

  // R2
  any_act_forces_c0_chk: assert property (@(posedge clk) disable iff (rst)
    any_act |=> core_state == ST_ACT);

  // R4
  c1e_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !c1e_en |=> core_state != ST_L1E);

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(enter_strb && exit_strb));

  // R7
  enter_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (enter_strb == (core_state != $past(core_state) && core_state != ST_ACT)));

  // R8
  idle_via_c0_chk: assert property (@(posedge clk) disable iff (rst)
    (core_state != ST_ACT) |=> (core_state == $past(core_state) || core_state == ST_ACT));

  // R9
  thread_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_bad && core_state <= ST_L7);
endmodule

bind idle_resolver idle_resolver_chk #(.NT(NT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .c1e_en       (c1e_en),
  .thread_state (thread_state),
  .core_state   (core_state),
  .enter_strb   (enter_strb),
  .exit_strb    (exit_strb)
);

// File: tb/idle_resolver_tb.sv
module idle_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A = 3'd0, L1 = 3'd1, L1E = 3'd2, L3 = 3'd3, L6 = 3'd4, L7 = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_valid = '0;
  logic [5:0] req_code = '0;
  logic [1:0] halt_req = '0;
  logic [1:0] wake = '0;
  logic       c1e_en = 1'b0;
  logic       pkg_idle_ok = 1'b0;
  logic [5:0] thread_state;
  logic [2:0] core_state;
  logic       enter_strb, exit_strb;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_resolver u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .halt_req(halt_req), .wake(wake), .c1e_en(c1e_en), .pkg_idle_ok(pkg_idle_ok),
    .thread_state(thread_state), .core_state(core_state),
    .enter_strb(enter_strb), .exit_strb(exit_strb)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic req2(logic [1:0] m, logic [2:0] c0, logic [2:0] c1);
    req_valid = m; req_code = {c1, c0};
    tick();
    req_valid = '0; req_code = '0;
  endtask

  task automatic wake_m(logic [1:0] m);
    wake = m; tick(); wake = '0;
  endtask

  task automatic t_reset();
    chk("R1 core after reset", core_state, A);
    chk("R1 threads after reset", thread_state, 0);
    chk("R1 strobes after reset", {enter_strb, exit_strb}, 0);
  endtask

  task automatic t_same();
    req2(2'b11, L6, L6);
    chk("R2 thread states", thread_state, {L6, L6});
    chk("R7 core lags threads", core_state, A);
    tick();
    chk("R2 both C6", core_state, L6);
    chk("R7 enter pulse", {enter_strb, exit_strb}, 2'b10);
    tick();
    chk("R7 enter one cycle", enter_strb, 0);
    wake_m(2'b01);
    tick();
    chk("R2 one thread C0", core_state, A);
    chk("R7 exit pulse", {enter_strb, exit_strb}, 2'b01);
    wake_m(2'b10);
    tick();
    chk("R7 no strobe w/o change", {enter_strb, exit_strb}, 0);
  endtask

  task automatic t_min();
    req2(2'b11, L3, L7); tick();
    chk("R3 C3+C7", core_state, L3);
    wake_m(2'b11); tick();
    req2(2'b11, L7, L6); tick();
    chk("R3 C7+C6", core_state, L6);
    wake_m(2'b11); tick();
    req2(2'b11, L1, L7); tick();
    chk("R3 C1+C7", core_state, L1);
    wake_m(2'b11); tick();
  endtask

  task automatic t_c1e();
    c1e_en = 1; pkg_idle_ok = 1;
    req2(2'b11, L1, L3); tick();
    chk("R4 C1E promoted", core_state, L1E);
    pkg_idle_ok = 0; tick();
    chk("R8 C1E->C1 via C0", core_state, A);
    tick();
    chk("R4 no package idle", core_state, L1);
    c1e_en = 0; pkg_idle_ok = 1; tick(); tick();
    chk("R4 disabled", core_state, L1);
    wake_m(2'b11); tick();
    pkg_idle_ok = 0;
  endtask

  task automatic t_c0pass();
    c1e_en = 1;
    req2(2'b11, L1, L1); tick();
    chk("R8 start C1", core_state, L1);
    pkg_idle_ok = 1; tick();
    chk("R8 C0 gap", core_state, A);
    chk("R8 exit on gap", {enter_strb, exit_strb}, 2'b01);
    tick();
    chk("R8 then C1E", core_state, L1E);
    chk("R8 enter after gap", {enter_strb, exit_strb}, 2'b10);
    wake_m(2'b11); tick();
    c1e_en = 0; pkg_idle_ok = 0;
  endtask

  task automatic t_halt();
    halt_req = 2'b01; req_valid = 2'b01; req_code = {A, L6};
    tick();
    halt_req = 0; req_valid = 0; req_code = 0;
    chk("R5 halt beats request", thread_state[2:0], L1);
    halt_req = 2'b10; tick(); halt_req = 0; tick();
    chk("R5 both halted core", core_state, L1);
    wake_m(2'b11); tick();
  endtask

  task automatic t_reroute();
    req2(2'b01, L3, A);
    chk("R6 enter C3", thread_state[2:0], L3);
    req2(2'b01, L6, A);
    chk("R6 bounce C0", thread_state[2:0], A);
    tick();
    chk("R6 then C6", thread_state[2:0], L6);
    req2(2'b01, L6, A);
    chk("R6 same-state no bounce", thread_state[2:0], L6);
    wake_m(2'b01);
  endtask

  task automatic t_invalid();
    req2(2'b01, 3'd2, A);
    chk("R9 code 2 ignored", thread_state[2:0], A);
    req2(2'b01, 3'd7, A);
    chk("R9 code 7 ignored", thread_state[2:0], A);
    req2(2'b10, L3, L3);
    req2(2'b10, A, 3'd6);
    chk("R9 code 6 while idle", thread_state[5:3], L3);
    req2(2'b10, A, 3'd0);
    chk("R9 code 0 ignored", thread_state[5:3], L3);
    wake_m(2'b10);
  endtask

  task automatic t_wake();
    req_valid = 2'b01; req_code = {A, L7}; wake = 2'b01;
    tick();
    req_valid = 0; req_code = 0; wake = 0;
    chk("R10 wake beats request", thread_state[2:0], A);
    req2(2'b01, L3, A);
    req2(2'b01, L7, A);
    wake_m(2'b01);
    tick();
    chk("R10 pending cancelled", thread_state[2:0], A);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        rst = 0;
        t_reset();
        t_same();
        t_min();
        t_c1e();
        t_c0pass();
        t_halt();
        t_reroute();
        t_invalid();
        t_wake();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule